// File: doc/BRIEF.md
# PCM Frame Bit-Offset Aligner

This block lines up an internal PCM frame with an external frame sync. It runs on the PCM bit clock, which moves one bit per period (2048 kHz in the usual setup). It samples the sync pulse on a selectable clock edge. On each detected sync it reloads two independent bit counters, one for the receive (downstream) direction and one for the transmit (upstream) direction, each from its own programmable offset. Each counter drives a timeslot index, a bit-within-timeslot index and a start-of-frame strobe for its direction.

Software computes the offsets. It takes the wanted bit position, adds a fixed pipeline correction (minus 17 downstream, plus 23 upstream) and reduces the result modulo the frame length. It then writes the upper eight bits of the 10-bit result. Two more settings choose the clock edge used to sample receive data and the edge used to drive transmit data. A sync that does not fall one frame after the previous one resynchronizes both counters at once and raises a one-clock slip flag.

A small state machine controls the block. It has two states. `FA_HUNT` is entered at reset; the counters hold at zero and no strobes are produced. `FA_LOCK` is entered from `FA_HUNT` on the first detected sync (transition *acquire*) and stays in `FA_LOCK` on every later sync (transition *resync*, flagged as a slip when it is off the boundary) and on every other cycle (transition *run*).

Top module: `pcm_frame_align`

## Requirements
- R1: After reset and until the first detected sync, both counters read 0 (slot 0, bit index 7), both start-of-frame strobes are 0 and the slip flag is 0.
- R2: With `fs_rise_sel`=0 the sync is sampled on the falling clock edge, and the counters reload at the first rising edge after the falling edge that sees it high. With `fs_rise_sel`=1 it is sampled on the rising edge, and the reload happens one rising edge later than in the falling-edge mode.
- R3: On a reload each counter takes its offset register times four: the register fills counter bits [9:2] and bits [1:0] are zero. For example, a downstream target of bit 2 in a 256-bit frame gives (2-17+256) mod 256 = 241, so the register holds 60 and the counter loads 240. An upstream target of bit 2 gives 25, so the register holds 6 and the counter loads 24.
- R4: While locked, each counter advances by one per rising clock edge and wraps from `frame_bits`-1 to 0. Frame lengths of 256 and 384 bits are supported.
- R5: Each timeslot index equals its counter divided by 8. Each bit index equals 7 minus the counter's three low bits, so bit 7 goes out first in a timeslot.
- R6: While locked, a direction's start-of-frame strobe is 1 in exactly the cycles in which its counter reads 0.
- R7: A sync detected while locked, at a position other than the last bit of the running frame, raises `sync_slip` for one cycle. That cycle is the same one in which the counters show the reloaded values. A sync that arrives exactly one frame after the previous one, and the first sync after reset, raise no slip.
- R8: `edge_sel[1]`=1 samples `rxd` on the rising edge; 0 samples it on the falling edge. The sample is presented on `rxd_out` from the next rising edge.
- R9: `edge_sel[0]`=1 drives `txd_out` at the rising edge that captures `txd_in`; 0 drives it half a period later, on the following falling edge. The setting 01 therefore means transmit on the rising edge and receive on the falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCM bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | External frame sync |
| fs_rise_sel | input | 1 | Sync sampling edge: 0 falling, 1 rising |
| frame_bits | input | 10 | Bits per frame |
| ofs_dn | input | 8 | Downstream offset, counter bits [9:2] |
| ofs_up | input | 8 | Upstream offset, counter bits [9:2] |
| edge_sel | input | 2 | [1] receive sample on rising, [0] transmit drive on rising |
| rxd | input | 1 | Serial receive data |
| txd_in | input | 1 | Internal transmit bit |
| dn_slot | output | 7 | Downstream timeslot index |
| dn_bit | output | 3 | Downstream bit index |
| up_slot | output | 7 | Upstream timeslot index |
| up_bit | output | 3 | Upstream bit index |
| dn_sof | output | 1 | Downstream start of internal frame |
| up_sof | output | 1 | Upstream start of internal frame |
| sync_slip | output | 1 | Off-boundary sync seen |
| rxd_out | output | 1 | Retimed receive data |
| txd_out | output | 1 | Retimed transmit data |

## Verification
A sync can be detected in the same cycle in which a counter would wrap from its last bit to 0. In that case the reload must win, and the slip decision must use the frame position from just before the reload. The bench places syncs exactly one frame apart, so that detection falls on the last bit of the frame, and also a few bits early. In both cases it compares the counters, strobes and slip flag against an arithmetic frame model. The bench repeats this for both sync-sampling edges and for frames of 24, 256 and 384 bits.

// File: rtl/pcm_align_pkg.sv
package pcm_align_pkg;
    localparam int CNT_W_DEF = 10;

    typedef enum logic [0:0] {
        FA_HUNT = 1'b0,
        FA_LOCK = 1'b1
    } fa_state_t;
endpackage

// File: rtl/pcm_sync_sampler.sv
module pcm_sync_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic fsync,
    input  logic rise_sel,
    output logic det
);
    logic fs_n;
    logic fs_p;
    logic cur;
    logic prev;

    // falling-edge capture of the sync
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fs_n <= 1'b0;
        else        fs_n <= fsync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_p <= 1'b0;
            prev <= 1'b0;
        end else begin
            fs_p <= fsync;
            prev <= cur;
        end
    end

    always_comb cur = rise_sel ? fs_p : fs_n;
    always_comb det = cur & ~prev;

    // R2: a detection is a single-cycle event
    p_det_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        det && $stable(rise_sel) |=> !det);
endmodule

// File: rtl/pcm_bit_counter.sv
module pcm_bit_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] frame_bits,
    output logic [CNT_W-1:0] cnt,
    output logic             at_end
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_comb at_end = (cnt >= frame_bits - ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (load)   cnt <= load_val;
        else if (run)    cnt <= at_end ? '0 : cnt + ONE;
    end

    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run && !load && !at_end |=> cnt == $past(cnt) + ONE);
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run && !load && at_end |=> cnt == '0);
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !load |=> $stable(cnt));
endmodule

// File: rtl/pcm_edge_retime.sv
module pcm_edge_retime (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_rise,
    input  logic tx_rise,
    input  logic rxd,
    input  logic txd_in,
    output logic rxd_out,
    output logic txd_out
);
    logic rx_n;
    logic tx_p;
    logic tx_n;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_n <= 1'b0;
            tx_n <= 1'b0;
        end else begin
            rx_n <= rxd;
            tx_n <= tx_p;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxd_out <= 1'b0;
            tx_p    <= 1'b0;
        end else begin
            rxd_out <= rx_rise ? rxd : rx_n;
            tx_p    <= txd_in;
        end
    end

    always_comb txd_out = tx_rise ? tx_p : tx_n;

    p_rx_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(rx_rise) |-> rxd_out == $past(rxd));
    p_tx_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && tx_rise |-> txd_out == $past(txd_in));
endmodule

// File: rtl/pcm_frame_align.sv
module pcm_frame_align
    import pcm_align_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fsync,
    input  logic               fs_rise_sel,
    input  logic [CNT_W-1:0]   frame_bits,
    input  logic [CNT_W-3:0]   ofs_dn,
    input  logic [CNT_W-3:0]   ofs_up,
    input  logic [1:0]         edge_sel,
    input  logic               rxd,
    input  logic               txd_in,
    output logic [CNT_W-4:0]   dn_slot,
    output logic [2:0]         dn_bit,
    output logic [CNT_W-4:0]   up_slot,
    output logic [2:0]         up_bit,
    output logic               dn_sof,
    output logic               up_sof,
    output logic               sync_slip,
    output logic               rxd_out,
    output logic               txd_out
);
    localparam int NDIR = 2;   // 0 downstream, 1 upstream

    fa_state_t state_q, state_d;
    logic det;
    logic run;
    logic pos_end;
    logic [CNT_W-1:0] pos_cnt;
    logic [CNT_W-1:0] cnt    [NDIR];
    logic [CNT_W-1:0] ld_val [NDIR];
    logic             c_end  [NDIR];
    logic             sof    [NDIR];

    pcm_sync_sampler u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync    (fsync),
        .rise_sel (fs_rise_sel),
        .det      (det)
    );

    always_comb run = (state_q == FA_LOCK);

    // frame position tracker, zero at each sync
    pcm_bit_counter #(.CNT_W(CNT_W)) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .load       (det),
        .load_val   ('0),
        .frame_bits (frame_bits),
        .cnt        (pos_cnt),
        .at_end     (pos_end)
    );

    always_comb begin
        ld_val[0] = {ofs_dn, 2'b00};
        ld_val[1] = {ofs_up, 2'b00};
    end

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        pcm_bit_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .run        (run),
            .load       (det),
            .load_val   (ld_val[g]),
            .frame_bits (frame_bits),
            .cnt        (cnt[g]),
            .at_end     (c_end[g])
        );
        always_comb sof[g] = run && (cnt[g] == '0);

        // R6: strobe lasts one clock unless a reload to zero follows
        p_sof_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
            sof[g] && !det && frame_bits > CNT_W'(1) |=> !sof[g]);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FA_HUNT;
        else        state_q <= state_d;
    end

    // transitions: acquire, run, resync
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FA_HUNT: if (det) state_d = FA_LOCK;
            FA_LOCK: state_d = FA_LOCK;
            default: state_d = FA_HUNT;
        endcase
    end

    // registered outputs of the machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_slip <= 1'b0;
        else begin
            unique case (state_q)
                FA_HUNT: sync_slip <= 1'b0;
                FA_LOCK: sync_slip <= det && !pos_end;
                default: sync_slip <= 1'b0;
            endcase
        end
    end

    always_comb begin
        dn_slot = cnt[0][CNT_W-1:3];
        dn_bit  = ~cnt[0][2:0];
        up_slot = cnt[1][CNT_W-1:3];
        up_bit  = ~cnt[1][2:0];
        dn_sof  = sof[0];
        up_sof  = sof[1];
    end

    pcm_edge_retime u_retime (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_rise (edge_sel[1]),
        .tx_rise (edge_sel[0]),
        .rxd     (rxd),
        .txd_in  (txd_in),
        .rxd_out (rxd_out),
        .txd_out (txd_out)
    );

    p_slip_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_slip |-> $past(state_q) == FA_LOCK && $past(det));
    p_slip_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_slip |=> !sync_slip);
    p_hunt_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == FA_HUNT |-> !dn_sof && !up_sof && !sync_slip);
    p_lock_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == FA_LOCK |=> state_q == FA_LOCK);
endmodule

// File: tb/test_pcm_frame_align.sv
`timescale 1ns/100ps
module test_pcm_frame_align;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fsync = 1'b0;
    logic fs_rise_sel = 1'b0;
    logic [9:0] frame_bits = 10'd24;
    logic [7:0] ofs_dn = '0;
    logic [7:0] ofs_up = '0;
    logic [1:0] edge_sel = 2'b01;
    logic rxd = 1'b0;
    logic txd_in = 1'b0;
    logic [6:0] dn_slot, up_slot;
    logic [2:0] dn_bit, up_bit;
    logic dn_sof, up_sof, sync_slip, rxd_out, txd_out;

    always #2 clk = ~clk;   // 250 MHz

    pcm_frame_align i_pcm_frame_align (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .fs_rise_sel(fs_rise_sel),
        .frame_bits(frame_bits), .ofs_dn(ofs_dn), .ofs_up(ofs_up),
        .edge_sel(edge_sel), .rxd(rxd), .txd_in(txd_in),
        .dn_slot(dn_slot), .dn_bit(dn_bit), .up_slot(up_slot), .up_bit(up_bit),
        .dn_sof(dn_sof), .up_sof(up_sof), .sync_slip(sync_slip),
        .rxd_out(rxd_out), .txd_out(txd_out)
    );

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // model state
    int fb, ld, lu, cd, cu, epos;
    bit locked, p1, p2, h1, h2, ra, rb;
    logic [15:0] lfsr = 16'hACE1;

    function automatic bit nbit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input bit fs);
        bit d, eslip, bv;
        string ctag;
        @(posedge clk);
        d = p1; p1 = p2; p2 = 0;
        eslip = d && locked && (epos != fb - 1);
        if (d) begin
            cd = ld; cu = lu; epos = 0; locked = 1;
        end else if (locked) begin
            cd = (cd >= fb - 1) ? 0 : cd + 1;
            cu = (cu >= fb - 1) ? 0 : cu + 1;
            epos = (epos >= fb - 1) ? 0 : epos + 1;
        end
        #0.5;
        ctag = !locked ? "R1 counter" : (d ? "R2/R3 reload" : "R4 count");
        chk({ctag, " dn_slot R5"}, int'(dn_slot), cd / 8);
        chk({ctag, " dn_bit R5"}, int'(dn_bit), 7 - (cd % 8));
        chk({ctag, " up_slot R5"}, int'(up_slot), cu / 8);
        chk({ctag, " up_bit R5"}, int'(up_bit), 7 - (cu % 8));
        chk("R6 dn_sof", int'(dn_sof), int'(locked && cd == 0));
        chk("R6 up_sof", int'(up_sof), int'(locked && cu == 0));
        chk("R7 sync_slip", int'(sync_slip), int'(eslip));
        chk("R8 rxd_out", int'(rxd_out), int'(edge_sel[1] ? rb : ra));
        chk("R9 txd_out", int'(txd_out), int'(edge_sel[0] ? h1 : h2));
        #0.5;
        fsync = fs;
        if (fs) begin
            if (fs_rise_sel) p2 = 1; else p1 = 1;
        end
        h2 = h1; bv = nbit(); txd_in = bv; h1 = bv;
        bv = nbit(); rxd = bv; ra = bv;
        @(negedge clk);
        #0.5;
        bv = nbit(); rxd = bv; rb = bv;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0);
    endtask

    task automatic scenario(input bit mode, input int bits, input int odn,
                            input int oup, input logic [1:0] es);
        @(posedge clk); #1;
        rst_n = 0; fsync = 0; rxd = 0; txd_in = 0;
        fs_rise_sel = mode; frame_bits = 10'(bits);
        ofs_dn = 8'(odn); ofs_up = 8'(oup); edge_sel = es;
        fb = bits; ld = odn * 4; lu = oup * 4;
        cd = 0; cu = 0; epos = 0; locked = 0; p1 = 0; p2 = 0;
        h1 = 0; h2 = 0; ra = 0; rb = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        idle(5);                 // R1 hunt state
        cyc(1'b1); idle(fb - 1); // acquire
        cyc(1'b1); idle(fb - 1); // on boundary: no slip (R7)
        cyc(1'b1); idle(fb - 6); // boundary, then early sync
        cyc(1'b1); idle(fb + 4); // slip (R7)
        cyc(1'b1); idle(fb + 2); // late sync after run: slip
    endtask

    initial begin
        // R3: offset values from the programming rule
        scenario(1'b0, 24, 3, 5, 2'b01);
        scenario(1'b1, 24, 5, 0, 2'b10);
        scenario(1'b1, 256, ((2 - 17 + 256) % 256) >> 2, ((2 + 23) % 256) >> 2, 2'b11);
        scenario(1'b0, 384, ((2 - 17 + 384) % 384) >> 2, ((2 + 23) % 384) >> 2, 2'b00);
        scenario(1'b0, 16, 3, 2, 2'b01);   // load 12 and 8 near the wrap
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule